// File: doc/BRIEF.md
# Serial Command Word Receiver

This block is a write-only slave for a three-wire serial link: an active-low frame select, a serial clock and a data line. The host pulls the select low, then shifts one 32-bit command word most significant bit first. The block samples a bit on each falling serial-clock edge. All three lines are first brought into the faster system clock through two-flop synchronizers, and their edges are found there. The system clock must run at least four times faster than the serial clock.

When the 32nd bit arrives, the word is split at once into control, channel address, data code and feature fields. The select line does not have to rise first. The fields are registered, and a one-cycle `cmd_valid` strobe marks them. Any further serial clocks in that frame are ignored. If the select line rises before the 32nd bit, the partial frame is dropped without a trace. The four prefix bits at the top of the word are never decoded.

The output carries no back-pressure. `cmd_valid` is a pulse that the consumer must take in the cycle it appears. Because a frame needs 32 serial-clock periods, pulses are always far apart. A parameter sets the data code to 16, 14 or 12 bits.

Top module: `serial_cmd_rx`

## Requirements
- R1: During and straight after reset, `cmd_valid` is 0 and `cmd_ctrl`, `cmd_addr`, `cmd_code` and `cmd_feat` are all 0.
- R2: Word bits are taken on falling serial-clock edges while selected, first bit = bit 31. `cmd_ctrl` = bits 27:24, `cmd_addr` = bits 23:20, `cmd_feat` = bits 3:0, and `cmd_code` = the upper DATA_BITS bits of the field in bits 19:4.
- R3: Each complete frame gives exactly one `cmd_valid` pulse, one system cycle wide. It appears three system cycles after the 32nd falling edge is first seen at the pin.
- R4: The field outputs change only in the cycle where `cmd_valid` is high, and hold their values otherwise.
- R5: Falling serial-clock edges after the 32nd one in the same frame change neither the fields nor `cmd_valid`.
- R6: A rise of the select line before the 32nd falling edge discards the frame: no pulse, and the fields keep their old values.
- R7: If the select line stays low after a complete frame, no new frame starts until the select line has risen and fallen again.
- R8: Bits 31:28 of the word do not affect any output.
- R9: If the 32nd falling edge and the select rise are seen in the same system cycle, the frame counts as complete and is delivered.
- R10: Serial-clock edges while the select line is high are ignored, and they leave no bits behind for the next frame.
- R11: With DATA_BITS = 12, `cmd_code` is word bits 19:8, and bits 7:4 are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_sel_n | input | 1 | Frame select, active low, asynchronous |
| ser_clk | input | 1 | Serial clock, bits taken on its falling edge |
| ser_din | input | 1 | Serial data, most significant bit first |
| cmd_valid | output | 1 | One-cycle strobe for a newly decoded word |
| cmd_ctrl | output | 4 | Control field |
| cmd_addr | output | 4 | Channel address field |
| cmd_code | output | DATA_BITS | Left-aligned data code |
| cmd_feat | output | 4 | Feature bits |

## Verification
Two functions can meet in one system cycle: completing a frame on its 32nd falling edge, and aborting a frame because the select line has risen. The bench provokes this by raising the select line on the same system-clock edge that drops the serial clock for the final bit. Both changes then pass through the synchronizers together. The result is judged by a behavioural model that treats completion as having priority, by a count of strobes, and by the decoded fields. A second case shows the other side: an early rise after 20 bits produces nothing.

// File: rtl/scf_pkg.sv
package scf_pkg;

  localparam int FRAME_LEN = 32;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_LOCK  = 2'd2
  } frame_state_e;

  typedef struct packed {
    logic [3:0]  prefix;
    logic [3:0]  ctrl;
    logic [3:0]  addr;
    logic [15:0] data;
    logic [3:0]  feat;
  } cmd_word_t;

endpackage

// File: rtl/scf_sync.sv
module scf_sync #(
  parameter int          WIDTH     = 3,
  parameter int          STAGES    = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= RESET_VAL;
        else        stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= RESET_VAL;
        else        stg[g] <= stg[g-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/scf_edge.sv
module scf_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_s,
  input  logic sck_s,
  output logic sel_fall,
  output logic sck_fall
);

  logic sel_q;
  logic sck_q;

  // select idles high, so a reset value of 1 prevents a false start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b1;
      sck_q <= 1'b0;
    end else begin
      sel_q <= sel_s;
      sck_q <= sck_s;
    end
  end

  assign sel_fall = sel_q & ~sel_s;
  assign sck_fall = sck_q & ~sck_s;

endmodule

// File: rtl/scf_shifter.sv
module scf_shifter
  import scf_pkg::*;
#(
  parameter int LEN   = FRAME_LEN,
  localparam int CNT_W = $clog2(LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_level,
  input  logic             sel_fall,
  input  logic             sck_fall,
  input  logic             din,
  output logic             done,
  output logic [LEN-1:0]   word_next,
  output frame_state_e     state,
  output logic [CNT_W-1:0] cnt
);

  logic [LEN-1:0] shreg;
  logic           last_bit;

  assign word_next = {shreg[LEN-2:0], din};
  assign last_bit  = (cnt == CNT_W'(LEN - 1));
  // completion outranks a simultaneous deselect
  assign done      = (state == ST_SHIFT) && sck_fall && last_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      shreg <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (sel_fall) begin
            state <= ST_SHIFT;
            cnt   <= '0;
          end
        end
        ST_SHIFT: begin
          if (sck_fall) begin
            shreg <= word_next;
            if (last_bit) begin
              state <= ST_LOCK;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
              if (sel_level) state <= ST_IDLE;
            end
          end else if (sel_level) begin
            state <= ST_IDLE;
          end
        end
        ST_LOCK: begin
          if (sel_level) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/scf_fields.sv
module scf_fields
  import scf_pkg::*;
#(
  parameter int DATA_BITS = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  cmd_word_t            word,
  output logic                 valid,
  output logic [3:0]           ctrl,
  output logic [3:0]           addr,
  output logic [DATA_BITS-1:0] code,
  output logic [3:0]           feat
);

  // the prefix and the don't-care data tail are never decoded
  logic unused_bits;
  assign unused_bits = ^{word.prefix, word.data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      ctrl  <= '0;
      addr  <= '0;
      code  <= '0;
      feat  <= '0;
    end else begin
      valid <= load;
      if (load) begin
        ctrl <= word.ctrl;
        addr <= word.addr;
        code <= word.data[15 -: DATA_BITS];
        feat <= word.feat;
      end
    end
  end

endmodule

// File: rtl/serial_cmd_rx.sv
module serial_cmd_rx
  import scf_pkg::*;
#(
  parameter int DATA_BITS   = 16,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(FRAME_LEN + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_sel_n,
  input  logic                 ser_clk,
  input  logic                 ser_din,
  output logic                 cmd_valid,
  output logic [3:0]           cmd_ctrl,
  output logic [3:0]           cmd_addr,
  output logic [DATA_BITS-1:0] cmd_code,
  output logic [3:0]           cmd_feat
);

  logic [2:0]           pins_s;
  logic                 sel_sync;
  logic                 sck_sync;
  logic                 din_sync;
  logic                 sel_fall;
  logic                 sck_fall;
  logic                 frame_done;
  logic [FRAME_LEN-1:0] word_next;
  frame_state_e         frame_state;
  logic [CNT_W-1:0]     bit_cnt;

  scf_sync #(
    .WIDTH    (3),
    .STAGES   (SYNC_STAGES),
    .RESET_VAL(3'b001)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({ser_din, ser_clk, frame_sel_n}),
    .q    (pins_s)
  );

  assign sel_sync = pins_s[0];
  assign sck_sync = pins_s[1];
  assign din_sync = pins_s[2];

  scf_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_s   (sel_sync),
    .sck_s   (sck_sync),
    .sel_fall(sel_fall),
    .sck_fall(sck_fall)
  );

  scf_shifter #(
    .LEN(FRAME_LEN)
  ) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_level(sel_sync),
    .sel_fall (sel_fall),
    .sck_fall (sck_fall),
    .din      (din_sync),
    .done     (frame_done),
    .word_next(word_next),
    .state    (frame_state),
    .cnt      (bit_cnt)
  );

  scf_fields #(
    .DATA_BITS(DATA_BITS)
  ) u_fields (
    .clk  (clk),
    .rst_n(rst_n),
    .load (frame_done),
    .word (cmd_word_t'(word_next)),
    .valid(cmd_valid),
    .ctrl (cmd_ctrl),
    .addr (cmd_addr),
    .code (cmd_code),
    .feat (cmd_feat)
  );

endmodule

// File: rtl/scf_rx_chk.sv
module scf_rx_chk
  import scf_pkg::*;
#(
  parameter int DATA_BITS = 16,
  parameter int CNT_W     = 6
) (
  input logic                 clk,
  input logic                 rst_n,
  input frame_state_e         state,
  input logic [CNT_W-1:0]     cnt,
  input logic                 valid,
  input logic [3:0]           ctrl,
  input logic [3:0]           addr,
  input logic [DATA_BITS-1:0] code,
  input logic [3:0]           feat
);

  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SHIFT) |-> (cnt <= CNT_W'(FRAME_LEN - 1)));

  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

  assert_pulse_origin_R3: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ($past(state) == ST_SHIFT));

  assert_fields_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> $stable({ctrl, addr, code, feat}));

  assert_lock_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOCK) |=> (state != ST_SHIFT));

  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |=> !valid);

endmodule

bind serial_cmd_rx scf_rx_chk #(
  .DATA_BITS(DATA_BITS),
  .CNT_W    (CNT_W)
) u_chk (
  .clk  (clk),
  .rst_n(rst_n),
  .state(frame_state),
  .cnt  (bit_cnt),
  .valid(cmd_valid),
  .ctrl (cmd_ctrl),
  .addr (cmd_addr),
  .code (cmd_code),
  .feat (cmd_feat)
);

// File: tb/serial_cmd_rx_tb.sv
module serial_cmd_rx_tb;

  localparam int H = 3; // serial half-period in system cycles

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, sel_n, sck, sdi;
  logic        v16, v12;
  logic [3:0]  ctrl, addr, feat, ctrl12, addr12, feat12;
  logic [15:0] code;
  logic [11:0] code12;

  serial_cmd_rx #(.DATA_BITS(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .frame_sel_n(sel_n), .ser_clk(sck), .ser_din(sdi),
    .cmd_valid(v16), .cmd_ctrl(ctrl), .cmd_addr(addr), .cmd_code(code), .cmd_feat(feat));

  serial_cmd_rx #(.DATA_BITS(12)) u_dut12 (
    .clk(clk), .rst_n(rst_n), .frame_sel_n(sel_n), .ser_clk(sck), .ser_din(sdi),
    .cmd_valid(v12), .cmd_ctrl(ctrl12), .cmd_addr(addr12), .cmd_code(code12), .cmd_feat(feat12));

  int n_cmp = 0, n_bad = 0, n_pulse = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference: pin history delayed by the two-stage input path
  logic [2:0]  p1, p2, p3;
  int          mstate, mcnt;
  logic [31:0] mword;
  logic        e_valid;
  logic [3:0]  e_ctrl, e_addr, e_feat;
  logic [15:0] e_code;
  logic [11:0] e_code12;

  always @(posedge clk) begin
    if (!rst_n) begin
      p1 = 3'b001; p2 = 3'b001; p3 = 3'b001;
      mstate = 0; mcnt = 0; mword = '0; e_valid = 0;
      e_ctrl = 0; e_addr = 0; e_feat = 0; e_code = 0; e_code12 = 0;
    end else begin
      bit fall_c, fall_s, lvl, d;
      fall_c = p3[1] & ~p2[1];
      fall_s = p3[0] & ~p2[0];
      lvl = p2[0];
      d = p2[2];
      e_valid = 0;
      if (mstate == 0) begin
        if (fall_s) begin mstate = 1; mcnt = 0; end
      end else if (mstate == 1) begin
        if (fall_c) begin
          mword = {mword[30:0], d};
          mcnt++;
          if (mcnt == 32) begin
            e_valid = 1; mstate = 2;
            e_ctrl = mword[27:24]; e_addr = mword[23:20];
            e_code = mword[19:4]; e_code12 = mword[19:8]; e_feat = mword[3:0];
          end else if (lvl) mstate = 0;
        end else if (lvl) mstate = 0;
      end else begin
        if (lvl) mstate = 0;
      end
      p3 = p2; p2 = p1; p1 = {sdi, sck, sel_n};
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check(v16 === e_valid, "R3 strobe", {31'd0, v16}, {31'd0, e_valid});
      check({ctrl, addr, code, feat} === {e_ctrl, e_addr, e_code, e_feat}, "R2 fields",
            {ctrl, addr, code, feat}, {e_ctrl, e_addr, e_code, e_feat});
      check(v12 === e_valid && code12 === e_code12 && feat12 === e_feat, "R11 narrow code",
            {19'd0, v12, code12}, {19'd0, e_valid, e_code12});
      if (v16) n_pulse++;
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bitclk(input bit b);
    sdi = b; sck = 1'b1; wait_n(H);
    sck = 1'b0; wait_n(H);
  endtask

  task automatic frame(input logic [31:0] w, input int nbits, input bit keep_low);
    sel_n = 1'b0; wait_n(H);
    for (int i = 0; i < nbits; i++) bitclk(i < 32 ? w[31-i] : 1'b1);
    if (!keep_low) sel_n = 1'b1;
    wait_n(4*H);
  endtask

  task automatic frame_coinc(input logic [31:0] w);
    sel_n = 1'b0; wait_n(H);
    for (int i = 0; i < 31; i++) bitclk(w[31-i]);
    sdi = w[0]; sck = 1'b1; wait_n(H);
    sck = 1'b0; sel_n = 1'b1; wait_n(4*H);
  endtask

  task automatic expect_fields(input string tag, input logic [3:0] c, input logic [3:0] a,
                               input logic [15:0] k, input logic [3:0] f);
    check({ctrl, addr, code, feat} === {c, a, k, f}, tag, {ctrl, addr, code, feat}, {c, a, k, f});
  endtask

  task automatic expect_pulses(input string tag, input int base, input int add);
    check(n_pulse == base + add, tag, n_pulse - base, add);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int base;
    logic [31:0] snap;
    rst_n = 1'b0; sel_n = 1'b1; sck = 1'b0; sdi = 1'b0;
    wait_n(5);
    check(v16 === 1'b0 && {ctrl, addr, code, feat} === 28'd0, "R1 reset",
          {3'd0, v16, ctrl, addr, code, feat}, 32'd0);
    rst_n = 1'b1;
    wait_n(3);
    check(v16 === 1'b0 && {ctrl, addr, code, feat} === 28'd0 && code12 === 12'd0, "R1 after reset",
          {3'd0, v16, ctrl, addr, code, feat}, 32'd0);

    // R2 / R3 / R11: plain frame
    base = n_pulse;
    frame(32'h0ABCDEF5, 32, 0);
    expect_pulses("R3 one pulse per frame", base, 1);
    expect_fields("R2 decode", 4'hA, 4'hB, 16'hCDEF, 4'h5);
    check(code12 === 12'hCDE, "R11 12-bit code", {20'd0, code12}, 32'h0CDE);

    // R4: hold while idle
    snap = {4'd0, ctrl, addr, code, feat};
    wait_n(50);
    check({4'd0, ctrl, addr, code, feat} === snap, "R4 hold", {4'd0, ctrl, addr, code, feat}, snap);

    // R8: prefix is ignored
    frame(32'hF3C45A69, 32, 0);
    expect_fields("R8 prefix set", 4'h3, 4'hC, 16'h45A6, 4'h9);
    frame(32'h03C45A69, 32, 0);
    expect_fields("R8 prefix clear", 4'h3, 4'hC, 16'h45A6, 4'h9);

    // R5: extra clocks after the 32nd
    base = n_pulse;
    frame(32'h01234567, 40, 0);
    expect_pulses("R5 extra clocks", base, 1);
    expect_fields("R5 locked word", 4'h1, 4'h2, 16'h3456, 4'h7);

    // R6: early deselect
    base = n_pulse;
    frame(32'h0FFFFFFF, 20, 0);
    expect_pulses("R6 abort no pulse", base, 0);
    expect_fields("R6 fields kept", 4'h1, 4'h2, 16'h3456, 4'h7);

    // R10: clocks while deselected
    base = n_pulse;
    for (int i = 0; i < 10; i++) bitclk(1'b1);
    wait_n(4*H);
    expect_pulses("R10 no pulse when deselected", base, 0);
    frame(32'h0ABCDEF5, 32, 0);
    expect_fields("R10 clean next frame", 4'hA, 4'hB, 16'hCDEF, 4'h5);

    // R7: select held low across frames
    base = n_pulse;
    frame(32'h05551112, 32, 1);
    frame(32'h07777778, 32, 1);
    expect_pulses("R7 no restart without reselect", base, 1);
    expect_fields("R7 first word kept", 4'h5, 4'h5, 16'h5111, 4'h2);
    sel_n = 1'b1; wait_n(4*H);
    frame(32'h07777778, 32, 0);
    expect_pulses("R7 restart after reselect", base, 2);
    expect_fields("R7 second word", 4'h7, 4'h7, 16'h7777, 4'h8);

    // R9: last edge and deselect together
    base = n_pulse;
    frame_coinc(32'h09876543);
    expect_pulses("R9 coincident deselect completes", base, 1);
    expect_fields("R9 fields", 4'h9, 4'h8, 16'h7654, 4'h3);

    wait_n(10);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule